// File: doc/BRIEF.md
# Interleaved Bank Transaction Scheduler

This block turns a queue of two-unit read or write requests into command traffic for a packet-based DRAM channel. Each request carries a row address and two column addresses. Requests are handed to banks in a fixed rotation of four banks spaced two apart. Because of this spacing, a fresh activate can leave every row-to-row interval instead of once per full row cycle.

For every accepted request the scheduler drives one activate on the row-command port. It then drives two column commands on the column-command port and fills the companion extended-column slot. Writes get a mask with each write command and close the bank with auto-precharge on the second command. Reads close the bank with an explicit precharge in the extended slot. Data-slot strobes mark the cycles in which write data and read data occupy the data pins.

When traffic switches direction, the block adds turnaround gaps. It holds a write's first column command back after a read, and it holds a read's activate back after a write. Every timing value is a parameter. All command outputs show a no-op with zero fields in idle cycles.

Top module: `ilv_sched`

## Requirements
- R1: Accepted requests are assigned, in acceptance order since reset, to banks BASE_BANK, +2, +4, +6 (modulo 2^BANK_W), and the fifth wraps to BASE_BANK. The activate appears on the row port (row_cmd_o = 1) in the acceptance cycle and carries that bank and the request's row.
- R2: Two activates are never closer than T_RR cycles. Back-to-back requests of one type, or a write after a read, are accepted exactly T_RR cycles apart when nothing else stalls them.
- R3: A bank slot is not activated again until T_RC = 4*T_RR cycles after its previous activate. Until then req_ready_o stays low and the request waits.
- R4: Each request issues two column commands to its bank. The first comes T_RCD cycles after the activate and carries col0. The second comes exactly COL_GAP cycles later and carries col1. Encodings: 0 no-op, 1 read, 2 write, 3 write with auto-precharge. A write issues 2 then 3, and a read issues 1 then 1.
- R5: Every write column command (2 or 3) appears in the same cycle as a mask (xcol_cmd_o = 1) for the same bank.
- R6: A read request closes its bank with a precharge (xcol_cmd_o = 2) in the cycle of its second read command. The row port never carries anything but no-op (0) or activate (1).
- R7: wdata_slot_o is high exactly T_CWD cycles after each write column command.
- R8: rdata_slot_o is high exactly T_CAC cycles after each read column command.
- R9: A write whose preceding request was a read issues its first column command no earlier than BUB_RW+1 cycles after that read's last column command. If needed it is delayed past T_RCD to meet this.
- R10: A read accepted after a write is activated no earlier than T_RR+BUB_WR cycles after the write's activate.
- R11: A request is accepted only while the column engine is idle or is issuing the previous request's second column command.
- R12: After reset and in idle cycles, all command outputs are 0 with zero bank and address fields, both data strobes are low, and req_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_row_i | input | ROW_W | Row address |
| req_col0_i | input | COL_W | First column address |
| req_col1_i | input | COL_W | Second column address |
| req_ready_o | output | 1 | Request taken this cycle when valid |
| row_cmd_o | output | 2 | Row command: 0 no-op, 1 activate |
| row_bank_o | output | BANK_W | Bank of the activate |
| row_addr_o | output | ROW_W | Row of the activate |
| col_cmd_o | output | 2 | Column command: 0 no-op, 1 read, 2 write, 3 write with auto-precharge |
| col_bank_o | output | BANK_W | Bank of the column command |
| col_addr_o | output | COL_W | Column address |
| xcol_cmd_o | output | 2 | Extended column slot: 0 no-op, 1 mask, 2 precharge |
| xcol_bank_o | output | BANK_W | Bank of the extended command |
| wdata_slot_o | output | 1 | Write data occupies the data pins |
| rdata_slot_o | output | 1 | Read data occupies the data pins |

## Verification
On every cycle the assertions check four things. Activates keep the row-to-row spacing, and a read after a write keeps the longer spacing. Activated banks keep the parity of the base bank. On the column side, masks pair with write commands, precharge only rides on a read, the auto-precharge write follows a plain write, and the read-to-write column gap is kept. Several properties are left to the bench's scenarios, because only a reference schedule can show them. These are the exact acceptance cycles, the rotation order and its wrap, the data-strobe offsets, the column addresses, and the exact delay of a stalled write. The bench reaches them with long single-type runs, a write-to-read switch, an alternating read/read/write/write stream, and an isolated request after idle time.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {ROW_NOP = 2'd0, ROW_ACT = 2'd1} row_cmd_e;
  typedef enum logic [1:0] {COL_NOP = 2'd0, COL_RD = 2'd1, COL_WR = 2'd2, COL_WRA = 2'd3} col_cmd_e;
  typedef enum logic [1:0] {XC_NOP = 2'd0, XC_MSK = 2'd1, XC_PRE = 2'd2} xcol_cmd_e;
endpackage

// File: rtl/sched_dcnt.sv
module sched_dcnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sched_pdly.sv
module sched_pdly #(
  parameter int DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o
);
  if (DLY == 1) begin : g_one
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= in_i;
    end
    assign out_o = q;
  end else begin : g_sr
    logic [DLY-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[DLY-2:0], in_i};
    end
    assign out_o = sr_q[DLY-1];
  end
endmodule

// File: rtl/sched_col.sv
module sched_col
  import sched_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int COL_W   = 6,
  parameter int T_RCD   = 3,
  parameter int COL_GAP = 4,
  parameter int BUB_RW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [COL_W-1:0]  col0_i,
  input  logic [COL_W-1:0]  col1_i,
  output logic              free_o,
  output logic [1:0]        col_cmd_o,
  output logic [BANK_W-1:0] col_bank_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic [1:0]        xcol_cmd_o,
  output logic [BANK_W-1:0] xcol_bank_o
);
  localparam int CMAX = (T_RCD > COL_GAP) ? T_RCD : COL_GAP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int BW   = $clog2(BUB_RW + 2);
  localparam int SRW  = $clog2(BUB_RW + 3);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_GAP} st_e;

  st_e               st_q;
  logic [CW-1:0]     cnt_q;
  logic              j_wr_q;
  logic [BANK_W-1:0] j_bank_q;
  logic [COL_W-1:0]  j_c0_q, j_c1_q;
  logic              rw_clear, fire1, fire2;

  // read-to-write turnaround, armed by a read's last column command
  sched_dcnt #(.W(BW)) u_rw_bub (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .load_i(fire2 && !j_wr_q), .val_i(BW'(BUB_RW)), .zero_o(rw_clear)
  );

  assign fire1  = (st_q == S_WAIT) && (cnt_q == '0) && (!j_wr_q || rw_clear);
  assign fire2  = (st_q == S_GAP) && (cnt_q == '0);
  assign free_o = (st_q == S_IDLE) || fire2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      j_wr_q   <= 1'b0;
      j_bank_q <= '0;
      j_c0_q   <= '0;
      j_c1_q   <= '0;
    end else if (start_i) begin
      st_q     <= S_WAIT;
      cnt_q    <= CW'(T_RCD - 1);
      j_wr_q   <= wr_i;
      j_bank_q <= bank_i;
      j_c0_q   <= col0_i;
      j_c1_q   <= col1_i;
    end else if (fire1) begin
      st_q  <= S_GAP;
      cnt_q <= CW'(COL_GAP - 1);
    end else if (fire2) begin
      st_q <= S_IDLE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    col_cmd_o   = COL_NOP;
    col_bank_o  = '0;
    col_addr_o  = '0;
    xcol_cmd_o  = XC_NOP;
    xcol_bank_o = '0;
    if (fire1) begin
      col_cmd_o   = j_wr_q ? COL_WR : COL_RD;
      col_bank_o  = j_bank_q;
      col_addr_o  = j_c0_q;
      if (j_wr_q) begin
        xcol_cmd_o  = XC_MSK;
        xcol_bank_o = j_bank_q;
      end
    end else if (fire2) begin
      col_cmd_o   = j_wr_q ? COL_WRA : COL_RD;
      col_bank_o  = j_bank_q;
      col_addr_o  = j_c1_q;
      xcol_cmd_o  = j_wr_q ? XC_MSK : XC_PRE;
      xcol_bank_o = j_bank_q;
    end
  end

  // observation state for the checks below
  logic [1:0]     last_col_q;
  logic [SRW-1:0] since_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_col_q <= COL_NOP;
      since_rd_q <= SRW'(BUB_RW + 1);
    end else begin
      if (col_cmd_o != COL_NOP) last_col_q <= col_cmd_o;
      if (col_cmd_o == COL_RD)  since_rd_q <= SRW'(1);
      else if (since_rd_q < SRW'(BUB_RW + 1)) since_rd_q <= since_rd_q + 1'b1;
    end
  end

  p_mask_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd_o == COL_WR || col_cmd_o == COL_WRA) |-> (xcol_cmd_o == XC_MSK && xcol_bank_o == col_bank_o));
  p_pre_on_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xcol_cmd_o == XC_PRE) |-> (col_cmd_o == COL_RD));
  p_wra_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd_o == COL_WRA) |-> (last_col_q == COL_WR));
  p_rw_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_cmd_o == COL_WR && last_col_q == COL_RD) |-> (since_rd_q >= SRW'(BUB_RW + 1)));
endmodule

// File: rtl/ilv_sched.sv
module ilv_sched
  import sched_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int ROW_W     = 9,
  parameter int COL_W     = 6,
  parameter int BASE_BANK = 0,
  parameter int T_RR      = 8,
  parameter int T_RCD     = 3,
  parameter int COL_GAP   = 4,
  parameter int T_CWD     = 6,
  parameter int T_CAC     = 8,
  parameter int BUB_RW    = 4,
  parameter int BUB_WR    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_wr_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col0_i,
  input  logic [COL_W-1:0]  req_col1_i,
  output logic              req_ready_o,
  output logic [1:0]        row_cmd_o,
  output logic [BANK_W-1:0] row_bank_o,
  output logic [ROW_W-1:0]  row_addr_o,
  output logic [1:0]        col_cmd_o,
  output logic [BANK_W-1:0] col_bank_o,
  output logic [COL_W-1:0]  col_addr_o,
  output logic [1:0]        xcol_cmd_o,
  output logic [BANK_W-1:0] xcol_bank_o,
  output logic              wdata_slot_o,
  output logic              rdata_slot_o
);
  localparam int ROT = 4;
  localparam int T_RC = ROT * T_RR;
  localparam int TW  = $clog2(T_RC + BUB_WR + 1);
  localparam int SAT = T_RR + BUB_WR;
  localparam int SAW = $clog2(SAT + 2);

  logic [1:0]        slot_q;
  logic [BANK_W-1:0] tgt_bank;
  logic [ROT-1:0]    bank_free;
  logic              rr_zero, wr_rd_zero, col_free, accept;

  assign tgt_bank = BANK_W'(BASE_BANK + 2 * int'(slot_q));
  assign accept   = req_valid_i && req_ready_o;

  for (genvar g = 0; g < ROT; g++) begin : g_trc
    sched_dcnt #(.W(TW)) u_trc (
      .clk_i (clk_i), .rst_ni(rst_ni),
      .load_i(accept && slot_q == 2'(g)), .val_i(TW'(T_RC - 1)), .zero_o(bank_free[g])
    );
  end

  sched_dcnt #(.W(TW)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept), .val_i(TW'(T_RR - 1)), .zero_o(rr_zero)
  );

  // write-to-read row turnaround
  sched_dcnt #(.W(TW)) u_wr_bub (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept && req_wr_i), .val_i(TW'(T_RR + BUB_WR - 1)), .zero_o(wr_rd_zero)
  );

  assign req_ready_o = rr_zero && bank_free[slot_q] && (req_wr_i || wr_rd_zero) && col_free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     slot_q <= '0;
    else if (accept) slot_q <= slot_q + 1'b1;
  end

  assign row_cmd_o  = accept ? ROW_ACT : ROW_NOP;
  assign row_bank_o = accept ? tgt_bank : '0;
  assign row_addr_o = accept ? req_row_i : '0;

  sched_col #(
    .BANK_W(BANK_W), .COL_W(COL_W), .T_RCD(T_RCD), .COL_GAP(COL_GAP), .BUB_RW(BUB_RW)
  ) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (accept),
    .wr_i       (req_wr_i),
    .bank_i     (tgt_bank),
    .col0_i     (req_col0_i),
    .col1_i     (req_col1_i),
    .free_o     (col_free),
    .col_cmd_o  (col_cmd_o),
    .col_bank_o (col_bank_o),
    .col_addr_o (col_addr_o),
    .xcol_cmd_o (xcol_cmd_o),
    .xcol_bank_o(xcol_bank_o)
  );

  sched_pdly #(.DLY(T_CWD)) u_wdly (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_i(col_cmd_o == COL_WR || col_cmd_o == COL_WRA), .out_o(wdata_slot_o)
  );
  sched_pdly #(.DLY(T_CAC)) u_rdly (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_i(col_cmd_o == COL_RD), .out_o(rdata_slot_o)
  );

  // observation state for the checks below
  logic [SAW-1:0] since_act_q;
  logic           last_act_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q   <= SAW'(SAT);
      last_act_wr_q <= 1'b0;
    end else if (row_cmd_o == ROW_ACT) begin
      since_act_q   <= SAW'(1);
      last_act_wr_q <= req_wr_i;
    end else if (since_act_q < SAW'(SAT)) begin
      since_act_q <= since_act_q + 1'b1;
    end
  end

  p_act_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_cmd_o == ROW_ACT) |-> (since_act_q >= SAW'(T_RR)));
  p_rd_after_wr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_cmd_o == ROW_ACT && !req_wr_i && last_act_wr_q) |-> (since_act_q >= SAW'(SAT)));
  p_bank_parity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_cmd_o == ROW_ACT) |-> (row_bank_o[0] == 1'(BASE_BANK % 2)));
  p_row_enc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_cmd_o == ROW_NOP || row_cmd_o == ROW_ACT));
endmodule

// File: tb/ilv_sched_tb.sv
module ilv_sched_tb;
  localparam int BANK_W = 4, ROW_W = 9, COL_W = 6, BASE_BANK = 0;
  localparam int T_RR = 8, T_RCD = 3, COL_GAP = 4, T_CWD = 6, T_CAC = 8, BUB_RW = 4, BUB_WR = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_wr = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_c0 = '0, req_c1 = '0;
  logic req_ready;
  logic [1:0] row_cmd, col_cmd, xcol_cmd;
  logic [BANK_W-1:0] row_bank, col_bank, xcol_bank;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic wd_slot, rd_slot;

  always #5 clk = ~clk;

  ilv_sched #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .BASE_BANK(BASE_BANK), .T_RR(T_RR),
    .T_RCD(T_RCD), .COL_GAP(COL_GAP), .T_CWD(T_CWD), .T_CAC(T_CAC), .BUB_RW(BUB_RW), .BUB_WR(BUB_WR)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_wr_i(req_wr), .req_row_i(req_row),
    .req_col0_i(req_c0), .req_col1_i(req_c1), .req_ready_o(req_ready),
    .row_cmd_o(row_cmd), .row_bank_o(row_bank), .row_addr_o(row_addr),
    .col_cmd_o(col_cmd), .col_bank_o(col_bank), .col_addr_o(col_addr),
    .xcol_cmd_o(xcol_cmd), .xcol_bank_o(xcol_bank), .wdata_slot_o(wd_slot), .rdata_slot_o(rd_slot)
  );

  int cyc = 0;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  typedef struct { int cyc; int cmd; int bank; int addr; string rq; } ev_t;
  ev_t q_ev[3][$];
  int  q_st[2][$];
  int  n_chk = 0, n_fail = 0;
  bit  mon_on = 1'b0;

  int acc[64], c2a[64];
  bit wra[64];
  int nreq = 0;

  task automatic chk(input bit ok, input string rq, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", rq, msg);
    end
  endtask

  function automatic void push_ev(int p, int c, int cmd, int bank, int addr, string rq);
    ev_t e;
    e.cyc = c; e.cmd = cmd; e.bank = bank; e.addr = addr; e.rq = rq;
    q_ev[p].push_back(e);
  endfunction

  task automatic mon_port(input int p, input int cmd, input int bank, input int addr, input string nm);
    ev_t e;
    if (cmd != 0) begin
      if (q_ev[p].size() == 0)
        chk(1'b0, "R12", $sformatf("%s unexpected cmd %0d at %0d, expected no-op", nm, cmd, cyc));
      else begin
        e = q_ev[p].pop_front();
        chk(e.cyc == cyc && e.cmd == cmd && e.bank == bank && e.addr == addr, e.rq,
            $sformatf("%s actual cyc/cmd/bank/addr %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                      nm, cyc, cmd, bank, addr, e.cyc, e.cmd, e.bank, e.addr));
      end
    end else if (q_ev[p].size() > 0 && q_ev[p][0].cyc < cyc) begin
      e = q_ev[p].pop_front();
      chk(1'b0, e.rq, $sformatf("%s missing: actual none expected cmd %0d at %0d", nm, e.cmd, e.cyc));
    end
  endtask

  task automatic mon_strobe(input int p, input bit s, input string rq);
    int c;
    if (s) begin
      if (q_st[p].size() == 0) chk(1'b0, rq, $sformatf("strobe actual at %0d expected none", cyc));
      else begin
        c = q_st[p].pop_front();
        chk(c == cyc, rq, $sformatf("strobe actual %0d expected %0d", cyc, c));
      end
    end else if (q_st[p].size() > 0 && q_st[p][0] < cyc) begin
      c = q_st[p].pop_front();
      chk(1'b0, rq, $sformatf("strobe actual none expected %0d", c));
    end
  endtask

  // monitor: pops expected items as outputs appear
  initial forever begin
    @(negedge clk); #1;
    if (mon_on) begin
      mon_port(0, int'(row_cmd), int'(row_bank), int'(row_addr), "row");
      mon_port(1, int'(col_cmd), int'(col_bank), int'(col_addr), "col");
      mon_port(2, int'(xcol_cmd), int'(xcol_bank), 0, "xcol");
      mon_strobe(0, wd_slot, "R7");
      mon_strobe(1, rd_slot, "R8");
    end
  end

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // driver: compute the expected schedule from the requirements, then present the request
  task automatic send(input bit wr);
    int n = nreq, a, c1, c2, bank, row, k0, k1;
    string rt, ct;
    a = cyc; rt = "R1 R2"; ct = "R4";
    if (n > 0) begin
      a = mx(a, acc[n-1] + T_RR);
      if (wra[n-1] && !wr) begin a = mx(a, acc[n-1] + T_RR + BUB_WR); rt = "R1 R10"; end
      a = mx(a, c2a[n-1]);
    end
    if (n >= 4) begin a = mx(a, acc[n-4] + 4 * T_RR); rt = {rt, " R3"}; end
    c1 = a + T_RCD;
    if (n > 0 && !wra[n-1] && wr) begin c1 = mx(c1, c2a[n-1] + BUB_RW + 1); ct = "R4 R9"; end
    c2 = c1 + COL_GAP;
    bank = (BASE_BANK + 2 * (n % 4)) % (1 << BANK_W);
    row = (n * 37 + 5) % (1 << ROW_W);
    k0 = (n * 3) % (1 << COL_W);
    k1 = (n * 5 + 2) % (1 << COL_W);
    acc[n] = a; c2a[n] = c2; wra[n] = wr;
    push_ev(0, a, 1, bank, row, rt);
    push_ev(1, c1, wr ? 2 : 1, bank, k0, ct);
    push_ev(1, c2, wr ? 3 : 1, bank, k1, "R4");
    if (wr) begin
      push_ev(2, c1, 1, bank, 0, "R5");
      push_ev(2, c2, 1, bank, 0, "R5");
      q_st[0].push_back(c1 + T_CWD);
      q_st[0].push_back(c2 + T_CWD);
    end else begin
      push_ev(2, c2, 2, bank, 0, "R6");
      q_st[1].push_back(c1 + T_CAC);
      q_st[1].push_back(c2 + T_CAC);
    end
    req_valid = 1'b1; req_wr = wr; req_row = ROW_W'(row); req_c0 = COL_W'(k0); req_c1 = COL_W'(k1);
    forever begin
      #1;
      if (req_ready) break;
      @(negedge clk);
    end
    chk(cyc == a, "R3 R10 R11", $sformatf("accept of request %0d actual %0d expected %0d", n, cyc, a));
    nreq++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12: reset state
    chk(row_cmd == 0 && row_bank == 0 && row_addr == 0, "R12", $sformatf("row actual %0d expected 0", row_cmd));
    chk(col_cmd == 0 && col_bank == 0 && col_addr == 0, "R12", $sformatf("col actual %0d expected 0", col_cmd));
    chk(xcol_cmd == 0 && xcol_bank == 0, "R12", $sformatf("xcol actual %0d expected 0", xcol_cmd));
    chk(!wd_slot && !rd_slot, "R12", $sformatf("strobes actual %0d%0d expected 00", wd_slot, rd_slot));
    chk(req_ready, "R12", $sformatf("ready actual %0d expected 1", req_ready));
    mon_on = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 6; i++) send(1'b1);      // write run, rotation wrap
    for (int i = 0; i < 4; i++) send(1'b0);      // write-to-read switch, read run
    for (int i = 0; i < 2; i++) begin            // read/read/write/write
      send(1'b0); send(1'b0); send(1'b1); send(1'b1);
    end
    repeat (40) @(negedge clk);
    send(1'b0);                                  // isolated requests after idle
    send(1'b1);
    repeat (60) @(negedge clk);
    for (int p = 0; p < 3; p++)
      chk(q_ev[p].size() == 0, "R4", $sformatf("pending events port %0d actual %0d expected 0", p, q_ev[p].size()));
    chk(q_st[0].size() == 0, "R7", $sformatf("pending write strobes actual %0d expected 0", q_st[0].size()));
    chk(q_st[1].size() == 0, "R8", $sformatf("pending read strobes actual %0d expected 0", q_st[1].size()));
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule